// File: doc/BRIEF.md
# Rotated Framebuffer Scan Parameter Calculator

This block turns a framebuffer description and a display orientation into the six values that a double-indexed DMA address generator needs: a start (top) address, an end (bottom) address, an element count, a frame count, a signed element index and a signed frame index. The framebuffer is described by a base address, an element size, the visible X and Y resolution, a virtual line width and X/Y scale factors. The orientation is a rotation in degrees (0, 90, 180 or 270) plus a mirror flag, which gives eight scan orders in all.

A single `start` pulse while the block is idle captures all inputs. The block then computes the row stride, the full vertical span and the full horizontal span on one shared shift-add multiplier. It returns the results with a one-cycle `done` pulse, or rejects the request with a one-cycle `err` pulse. The results stay on the output pins until the next successful request. `start` and `done` are plain control strobes and there is no back-pressure. While `busy` is high, new `start` pulses are dropped, so a caller must wait for `busy` to fall before it issues another request.

Top module: `fb_scan_calc`

## Requirements
- R1: The address of pixel (x,y) is base + (y·W·SY + x·SX)·E modulo 2^32. E is 1, 2 or 4 bytes for `elem_size` codes 0, 1 and 2. W is the effective line width, and SX and SY are the effective scale factors. `top_addr` and `bot_addr` are such pixel addresses.
- R2: A `vwidth` of 0 means W = `xres`. An `xscale` or `yscale` of 0 means a scale factor of 1.
- R3: The step from pixel s to pixel d is addr(d) − addr(s) − E + 1, in two's complement. `elem_idx` carries its low 16 bits and `frame_idx` its low 32 bits.
- R4: The table below fixes, for each orientation, the top pixel, the bottom pixel, the element step and the frame step. X = xres−1 and Y = yres−1. In the step columns, a→b means the step from pixel a to pixel b.

| rot_deg | mirror | top | bottom | element step | frame step |
|---|---|---|---|---|---|
| 0 | 0 | (0,0) | (X,Y) | (0,0)→(1,0) | (X,0)→(0,1) |
| 0 | 1 | (X,0) | (0,Y) | (1,0)→(0,0) | (0,0)→(X,1) |
| 90 | 0 | (0,Y) | (X,0) | (0,1)→(0,0) | (0,0)→(1,Y) |
| 90 | 1 | (X,Y) | (0,0) | (0,1)→(0,0) | (1,0)→(0,Y) |
| 180 | 0 | (X,Y) | (0,0) | (1,0)→(0,0) | (0,1)→(X,0) |
| 180 | 1 | (0,Y) | (X,0) | (0,0)→(1,0) | (X,1)→(0,0) |
| 270 | 0 | (X,0) | (0,Y) | (0,0)→(0,1) | (1,Y)→(0,0) |
| 270 | 1 | (0,0) | (X,Y) | (0,0)→(0,1) | (0,Y)→(1,0) |

- R5: At 0 and 180 degrees `elem_cnt` = `xres` and `frame_cnt` = `yres`. At 90 and 270 degrees the two are swapped.
- R6: When `legacy` = 1, `elem_size` = 2, rotation is 0 and mirror is 0, `bot_addr` is 2 above the address of the last pixel. In every other case there is no such offset.
- R7: The request is rejected in three cases: `rot_deg` is not 0, 90, 180 or 270; `elem_size` = 3; or a nonzero `vwidth` is smaller than `xres`. A rejected request gives one `err` pulse and no `done` pulse, and all result outputs keep their previous values.
- R8: A `start` pulse while idle raises `busy` on the next cycle. Each accepted request ends with exactly one `done` or one `err` pulse, in the cycle in which `busy` has fallen. A `start` pulse while `busy` is high is ignored.
- R9: After reset `busy`, `done` and `err` are low and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe; all inputs are captured when it is seen while idle |
| base_addr | input | 32 | Byte address of pixel (0,0) |
| elem_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = invalid |
| xres | input | 16 | Visible pixels per line |
| yres | input | 16 | Visible lines |
| vwidth | input | 16 | Virtual line width in pixels; 0 = xres |
| xscale | input | 8 | Horizontal scale; 0 = 1 |
| yscale | input | 8 | Vertical scale; 0 = 1 |
| rot_deg | input | 9 | Rotation in degrees |
| mirror | input | 1 | Mirror the scan |
| legacy | input | 1 | Apply the bottom-address offset of R6 |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: results valid |
| err | output | 1 | One-cycle pulse: request rejected |
| top_addr | output | 32 | First address fetched |
| bot_addr | output | 32 | Last address bound |
| elem_cnt | output | 16 | Elements per frame |
| frame_cnt | output | 16 | Frames |
| elem_idx | output | 16 | Signed element step |
| frame_idx | output | 32 | Signed frame step |

## Verification
All eight orientations are run twice. The first pass uses default width and scales with 2-byte elements; it shows whether each orientation picks the right corner pixels and the right step directions. The second pass uses a wide virtual line, scales 2 and 3, and 4-byte elements, so a swap of row stride and column stride, or of the X and Y scales, gives different numbers. A large row stride checks that the 16-bit element step is truncated. Single-pixel frames, the legacy offset with each of its conditions broken in turn, the three reject causes, and a second request issued while busy cover the boundary cases.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;
  localparam int ROT_W = 9;

  typedef enum logic [1:0] {
    Q0   = 2'd0,
    Q90  = 2'd1,
    Q180 = 2'd2,
    Q270 = 2'd3
  } quad_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_MUL_ROW,
    S_MUL_Y,
    S_MUL_X,
    S_FINAL
  } phase_e;
endpackage

// File: rtl/fb_scan_norm.sv
module fb_scan_norm import fb_scan_pkg::*; #(
  parameter int DW = 16,
  parameter int SW = 8
)(
  input  logic [DW-1:0]    xres,
  input  logic [DW-1:0]    vwidth,
  input  logic [SW-1:0]    xscale,
  input  logic [SW-1:0]    yscale,
  input  logic [1:0]       esz,
  input  logic [ROT_W-1:0] rot_deg,
  output logic [DW-1:0]    vw_eff,
  output logic [SW-1:0]    xs_eff,
  output logic [SW-1:0]    ys_eff,
  output logic [1:0]       esh,
  output quad_e            quad,
  output logic             bad
);
  logic rot_bad, esz_bad, vw_bad;

  // R2: zero means default
  assign vw_eff = (vwidth == '0) ? xres : vwidth;
  assign xs_eff = (xscale == '0) ? SW'(1) : xscale;
  assign ys_eff = (yscale == '0) ? SW'(1) : yscale;

  always_comb begin
    rot_bad = 1'b0;
    quad    = Q0;
    case (rot_deg)
      ROT_W'(0):   quad = Q0;
      ROT_W'(90):  quad = Q90;
      ROT_W'(180): quad = Q180;
      ROT_W'(270): quad = Q270;
      default:     rot_bad = 1'b1;
    endcase
  end

  always_comb begin
    esz_bad = 1'b0;
    case (esz)
      2'd0:    esh = 2'd0;
      2'd1:    esh = 2'd1;
      2'd2:    esh = 2'd2;
      default: begin esh = 2'd0; esz_bad = 1'b1; end
    endcase
  end

  assign vw_bad = (vwidth != '0) && (vwidth < xres);
  assign bad    = rot_bad | esz_bad | vw_bad;  // R7
endmodule

// File: rtl/fb_scan_mul.sv
module fb_scan_mul #(
  parameter int AW = 32,
  parameter int BW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [AW-1:0] prod,
  output logic          done
);
  localparam int CW = $clog2(BW + 1);

  logic [AW-1:0] acc, a_sh;
  logic [BW-1:0] b_sh;
  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      a_sh <= '0;
      b_sh <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        acc  <= '0;
        a_sh <= a;
        b_sh <= b;
        cnt  <= CW'(BW);
        run  <= 1'b1;
      end else if (run) begin
        if (b_sh[0]) acc <= acc + a_sh;
        a_sh <= a_sh << 1;
        b_sh <= b_sh >> 1;
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign prod = acc;

  // R8: launches never overlap a running product
  a_r8_mul_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !run);
  // R8: completion is a single-cycle strobe
  a_r8_mul_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/fb_scan_orient.sv
module fb_scan_orient import fb_scan_pkg::*; #(
  parameter int AW  = 32,
  parameter int EIW = 16
)(
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  colb,
  input  logic [AW-1:0]  rowb,
  input  logic [AW-1:0]  xspan,
  input  logic [AW-1:0]  yspan,
  input  logic [1:0]     esh,
  input  quad_e          quad,
  input  logic           mirror,
  input  logic           bump,
  output logic [AW-1:0]  top,
  output logic [AW-1:0]  bot,
  output logic [EIW-1:0] eidx,
  output logic [AW-1:0]  fidx
);
  // tx/ty: top corner lies at the far X / far Y edge; bottom is the opposite corner
  logic tx, ty, e_neg, fa_neg, fb_neg;
  logic [AW-1:0] es_m1, e_mag, fa, fb, e_term, fa_t, fb_t;

  always_comb begin
    case ({quad, mirror})
      {Q0,   1'b0}: {tx, ty, e_neg, fa_neg, fb_neg} = 5'b00010;
      {Q0,   1'b1}: {tx, ty, e_neg, fa_neg, fb_neg} = 5'b10100;
      {Q90,  1'b0}: {tx, ty, e_neg, fa_neg, fb_neg} = 5'b01100;
      {Q90,  1'b1}: {tx, ty, e_neg, fa_neg, fb_neg} = 5'b11110;
      {Q180, 1'b0}: {tx, ty, e_neg, fa_neg, fb_neg} = 5'b11101;
      {Q180, 1'b1}: {tx, ty, e_neg, fa_neg, fb_neg} = 5'b01011;
      {Q270, 1'b0}: {tx, ty, e_neg, fa_neg, fb_neg} = 5'b10011;
      default:      {tx, ty, e_neg, fa_neg, fb_neg} = 5'b00001;
    endcase
  end

  // odd quadrants walk columns per element, even quadrants walk rows per frame
  assign e_mag  = quad[0] ? rowb  : colb;
  assign fa     = quad[0] ? colb  : xspan;
  assign fb     = quad[0] ? yspan : rowb;
  assign e_term = e_neg  ? (~e_mag + 1'b1) : e_mag;
  assign fa_t   = fa_neg ? (~fa + 1'b1)    : fa;
  assign fb_t   = fb_neg ? (~fb + 1'b1)    : fb;
  assign es_m1  = (AW'(1) << esh) - AW'(1);

  assign top  = base + (tx ? xspan : '0) + (ty ? yspan : '0);
  assign bot  = base + (tx ? '0 : xspan) + (ty ? '0 : yspan) + (bump ? AW'(2) : '0);
  assign eidx = EIW'(e_term - es_m1);
  assign fidx = fa_t + fb_t - es_m1;
endmodule

// File: rtl/fb_scan_calc.sv
module fb_scan_calc import fb_scan_pkg::*; #(
  parameter int AW  = 32,
  parameter int DW  = 16,
  parameter int SW  = 8,
  parameter int EIW = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base_addr,
  input  logic [1:0]       elem_size,
  input  logic [DW-1:0]    xres,
  input  logic [DW-1:0]    yres,
  input  logic [DW-1:0]    vwidth,
  input  logic [SW-1:0]    xscale,
  input  logic [SW-1:0]    yscale,
  input  logic [ROT_W-1:0] rot_deg,
  input  logic             mirror,
  input  logic             legacy,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [AW-1:0]    top_addr,
  output logic [AW-1:0]    bot_addr,
  output logic [DW-1:0]    elem_cnt,
  output logic [DW-1:0]    frame_cnt,
  output logic [EIW-1:0]   elem_idx,
  output logic [AW-1:0]    frame_idx
);
  phase_e st;

  logic [AW-1:0]    c_base;
  logic [1:0]       c_esz;
  logic [DW-1:0]    c_xres, c_yres, c_vw;
  logic [SW-1:0]    c_xs, c_ys;
  logic [ROT_W-1:0] c_rot;
  logic             c_mir, c_leg;

  logic [DW-1:0] vw_eff;
  logic [SW-1:0] xs_eff, ys_eff;
  logic [1:0]    esh;
  quad_e         quad;
  logic          bad;

  fb_scan_norm #(.DW(DW), .SW(SW)) u_norm (
    .xres(c_xres), .vwidth(c_vw), .xscale(c_xs), .yscale(c_ys),
    .esz(c_esz), .rot_deg(c_rot),
    .vw_eff(vw_eff), .xs_eff(xs_eff), .ys_eff(ys_eff),
    .esh(esh), .quad(quad), .bad(bad)
  );

  logic          mul_go, mul_done;
  logic [AW-1:0] mul_a, mul_prod;
  logic [DW-1:0] mul_b;
  logic [AW-1:0] rowb, yspan, xspan, colb;

  assign colb = AW'(xs_eff) << esh;

  always_comb begin
    case (st)
      S_MUL_Y: begin mul_a = rowb;           mul_b = c_yres - DW'(1); end
      S_MUL_X: begin mul_a = colb;           mul_b = c_xres - DW'(1); end
      default: begin mul_a = AW'(ys_eff);    mul_b = vw_eff;          end
    endcase
  end

  fb_scan_mul #(.AW(AW), .BW(DW)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(mul_go), .a(mul_a), .b(mul_b),
    .prod(mul_prod), .done(mul_done)
  );

  logic           bump;
  logic [AW-1:0]  o_top, o_bot, o_fidx;
  logic [EIW-1:0] o_eidx;

  assign bump = c_leg && (c_esz == 2'd2) && (quad == Q0) && !c_mir;  // R6

  fb_scan_orient #(.AW(AW), .EIW(EIW)) u_orient (
    .base(c_base), .colb(colb), .rowb(rowb), .xspan(xspan), .yspan(yspan),
    .esh(esh), .quad(quad), .mirror(c_mir), .bump(bump),
    .top(o_top), .bot(o_bot), .eidx(o_eidx), .fidx(o_fidx)
  );

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      c_base    <= '0;
      c_esz     <= '0;
      c_xres    <= '0;
      c_yres    <= '0;
      c_vw      <= '0;
      c_xs      <= '0;
      c_ys      <= '0;
      c_rot     <= '0;
      c_mir     <= 1'b0;
      c_leg     <= 1'b0;
      mul_go    <= 1'b0;
      rowb      <= '0;
      yspan     <= '0;
      xspan     <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      top_addr  <= '0;
      bot_addr  <= '0;
      elem_cnt  <= '0;
      frame_cnt <= '0;
      elem_idx  <= '0;
      frame_idx <= '0;
    end else begin
      mul_go <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          c_base <= base_addr;
          c_esz  <= elem_size;
          c_xres <= xres;
          c_yres <= yres;
          c_vw   <= vwidth;
          c_xs   <= xscale;
          c_ys   <= yscale;
          c_rot  <= rot_deg;
          c_mir  <= mirror;
          c_leg  <= legacy;
          st     <= S_CHECK;
        end
        S_CHECK: if (bad) begin
          err <= 1'b1;
          st  <= S_IDLE;
        end else begin
          mul_go <= 1'b1;
          st     <= S_MUL_ROW;
        end
        S_MUL_ROW: if (mul_done) begin
          rowb   <= mul_prod << esh;
          mul_go <= 1'b1;
          st     <= S_MUL_Y;
        end
        S_MUL_Y: if (mul_done) begin
          yspan  <= mul_prod;
          mul_go <= 1'b1;
          st     <= S_MUL_X;
        end
        S_MUL_X: if (mul_done) begin
          xspan <= mul_prod;
          st    <= S_FINAL;
        end
        default: begin
          top_addr  <= o_top;
          bot_addr  <= o_bot;
          elem_idx  <= o_eidx;
          frame_idx <= o_fidx;
          elem_cnt  <= quad[0] ? c_yres : c_xres;
          frame_cnt <= quad[0] ? c_xres : c_yres;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
      endcase
    end
  end

  // R8: completion strobes are exclusive
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  // R8: a completion follows a busy cycle
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> $past(busy));
  // R8: an idle start makes the block busy
  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R7: a rejection leaves the results untouched
  a_r7_err_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(top_addr) && $stable(frame_idx) && $stable(elem_idx)));
  // R5: counts follow the captured orientation
  a_r5_counts: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (elem_cnt == (quad[0] ? c_yres : c_xres)) && (frame_cnt == (quad[0] ? c_xres : c_yres)));
  // R1: results change only when done is raised
  a_r1_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(top_addr) |-> done);
endmodule

// File: tb/tb_fb_scan_calc.sv
`timescale 1ns/1ps
module tb_fb_scan_calc;
  typedef struct {
    logic [31:0] base;
    logic [1:0]  esz;
    logic [15:0] xr, yr, vw;
    logic [7:0]  xs, ys;
    logic [8:0]  rot;
    logic        mir, leg;
  } vec_t;

  typedef struct {
    bit          is_err;
    logic [31:0] top, bot, fi;
    logic [15:0] ec, fc, ei;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [1:0]  elem_size = '0;
  logic [15:0] xres = '0, yres = '0, vwidth = '0;
  logic [7:0]  xscale = '0, yscale = '0;
  logic [8:0]  rot_deg = '0;
  logic        mirror = 1'b0, legacy = 1'b0;
  logic        busy, done, err;
  logic [31:0] top_addr, bot_addr, frame_idx;
  logic [15:0] elem_cnt, frame_cnt, elem_idx;

  always #4 clk = ~clk;  // 125 MHz

  fb_scan_calc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .elem_size(elem_size), .xres(xres), .yres(yres), .vwidth(vwidth),
    .xscale(xscale), .yscale(yscale), .rot_deg(rot_deg), .mirror(mirror),
    .legacy(legacy), .busy(busy), .done(done), .err(err),
    .top_addr(top_addr), .bot_addr(bot_addr), .elem_cnt(elem_cnt),
    .frame_cnt(frame_cnt), .elem_idx(elem_idx), .frame_idx(frame_idx)
  );

  int n_chk = 0;
  int n_bad = 0;
  exp_t q[$];
  exp_t last;

  longint m_base, m_vw, m_xs, m_ys, m_es;

  function automatic longint pix(longint x, longint y);
    return m_base + (y * m_vw * m_ys + x * m_xs) * m_es;
  endfunction

  function automatic longint stp(longint sx, longint sy, longint dx, longint dy);
    return pix(dx, dy) - pix(sx, sy) - m_es + 1;
  endfunction

  function automatic exp_t model(vec_t v, string tag);
    exp_t e;
    longint xr, yr, t, b, ei, fi;
    e = last;
    e.tag = tag;
    e.is_err = !(v.rot == 0 || v.rot == 90 || v.rot == 180 || v.rot == 270) ||
               (v.esz == 2'd3) || (v.vw != 0 && v.vw < v.xr);
    if (e.is_err) return e;
    xr = longint'(v.xr);
    yr = longint'(v.yr);
    m_base = longint'(v.base);
    m_es   = longint'(1) << v.esz;
    m_vw   = (v.vw == 0) ? xr : longint'(v.vw);
    m_xs   = (v.xs == 0) ? 1 : longint'(v.xs);
    m_ys   = (v.ys == 0) ? 1 : longint'(v.ys);
    t = 0; b = 0; ei = 0; fi = 0;
    case ({v.rot, v.mir})
      {9'd0, 1'b0}:   begin t = pix(0, 0);       b = pix(xr-1, yr-1); ei = stp(0,0,1,0); fi = stp(xr-1,0,0,1); end
      {9'd0, 1'b1}:   begin t = pix(xr-1, 0);    b = pix(0, yr-1);    ei = stp(1,0,0,0); fi = stp(0,0,xr-1,1); end
      {9'd90, 1'b0}:  begin t = pix(0, yr-1);    b = pix(xr-1, 0);    ei = stp(0,1,0,0); fi = stp(0,0,1,yr-1); end
      {9'd90, 1'b1}:  begin t = pix(xr-1, yr-1); b = pix(0, 0);       ei = stp(0,1,0,0); fi = stp(1,0,0,yr-1); end
      {9'd180, 1'b0}: begin t = pix(xr-1, yr-1); b = pix(0, 0);       ei = stp(1,0,0,0); fi = stp(0,1,xr-1,0); end
      {9'd180, 1'b1}: begin t = pix(0, yr-1);    b = pix(xr-1, 0);    ei = stp(0,0,1,0); fi = stp(xr-1,1,0,0); end
      {9'd270, 1'b0}: begin t = pix(xr-1, 0);    b = pix(0, yr-1);    ei = stp(0,0,0,1); fi = stp(1,yr-1,0,0); end
      default:        begin t = pix(0, 0);       b = pix(xr-1, yr-1); ei = stp(0,0,0,1); fi = stp(0,yr-1,1,0); end
    endcase
    if (v.leg && v.esz == 2'd2 && v.rot == 0 && !v.mir) b = b + 2;  // R6
    e.top = t[31:0];
    e.bot = b[31:0];
    e.ei  = ei[15:0];
    e.fi  = fi[31:0];
    e.ec  = (v.rot == 90 || v.rot == 270) ? v.yr : v.xr;  // R5
    e.fc  = (v.rot == 90 || v.rot == 270) ? v.xr : v.yr;
    return e;
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp, inout bit bad);
    if (act !== exp) begin
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      bad = 1'b1;
    end
  endtask

  // monitor: pops one expected item per completion strobe
  always @(negedge clk) begin : monitor
    exp_t e;
    bit bad;
    if (rst_n && (done || err)) begin
      n_chk++;
      bad = 1'b0;
      if (q.size() == 0) begin
        $display("FAIL R8 unexpected completion actual=1 expected=0");
        n_bad++;
      end else begin
        e = q.pop_front();
        cmp(e.tag, "done", 32'(done), 32'(!e.is_err), bad);
        cmp(e.tag, "err",  32'(err),  32'(e.is_err),  bad);
        cmp(e.tag, "top",  top_addr,  e.top, bad);
        cmp(e.tag, "bot",  bot_addr,  e.bot, bad);
        cmp(e.tag, "ecnt", 32'(elem_cnt),  32'(e.ec), bad);
        cmp(e.tag, "fcnt", 32'(frame_cnt), 32'(e.fc), bad);
        cmp(e.tag, "eidx", 32'(elem_idx),  32'(e.ei), bad);
        cmp(e.tag, "fidx", frame_idx, e.fi, bad);
        if (bad) n_bad++;
      end
    end
  end

  task automatic drive(vec_t v);
    base_addr = v.base; elem_size = v.esz; xres = v.xr; yres = v.yr;
    vwidth = v.vw; xscale = v.xs; yscale = v.ys; rot_deg = v.rot;
    mirror = v.mir; legacy = v.leg;
  endtask

  task automatic push(vec_t v, string tag);
    exp_t e;
    e = model(v, tag);
    q.push_back(e);
    if (!e.is_err) last = e;
  endtask

  task automatic wait_end();
    @(negedge clk);
    while (!(done || err)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic apply(vec_t v, string tag);
    push(v, tag);
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_end();
  endtask

  function automatic vec_t mk(logic [31:0] b, logic [1:0] es, logic [15:0] x, logic [15:0] y,
                              logic [15:0] w, logic [7:0] sx, logic [7:0] sy,
                              logic [8:0] r, logic m, logic l);
    vec_t v;
    v.base = b; v.esz = es; v.xr = x; v.yr = y; v.vw = w;
    v.xs = sx; v.ys = sy; v.rot = r; v.mir = m; v.leg = l;
    return v;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    $display("FAIL R8 watchdog actual=hung expected=finished");
    n_bad++;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    vec_t va, vb;
    last.is_err = 1'b0; last.top = '0; last.bot = '0; last.fi = '0;
    last.ec = '0; last.fc = '0; last.ei = '0; last.tag = "";
    repeat (3) @(negedge clk);
    // R9: reset state
    n_chk++;
    if ({busy, done, err} !== 3'b000 || top_addr !== '0 || bot_addr !== '0 ||
        elem_idx !== '0 || frame_idx !== '0 || elem_cnt !== '0 || frame_cnt !== '0) begin
      $display("FAIL R9 reset outputs actual=%b/%h expected=000/0", {busy, done, err}, top_addr);
      n_bad++;
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R5 R2: all orientations, default width and scales, 2-byte elements
    for (int r = 0; r < 4; r++)
      for (int m = 0; m < 2; m++)
        apply(mk(32'h8000_0000, 2'd1, 16'd320, 16'd240, 16'd0, 8'd0, 8'd0, 9'(r*90), 1'(m), 1'b0),
              $sformatf("R4_R5 rot%0d mir%0d default", r*90, m));
    // R1 R3 R4: wide line, scales 2/3, 4-byte elements
    for (int r = 0; r < 4; r++)
      for (int m = 0; m < 2; m++)
        apply(mk(32'h0010_0000, 2'd2, 16'd100, 16'd60, 16'd160, 8'd2, 8'd3, 9'(r*90), 1'(m), 1'b0),
              $sformatf("R1_R3 rot%0d mir%0d scaled", r*90, m));
    // R2: explicit width equal to xres and scales of 1
    apply(mk(32'h8000_0000, 2'd1, 16'd320, 16'd240, 16'd320, 8'd1, 8'd1, 9'd90, 1'b0, 1'b0), "R2 explicit defaults");
    // R3: large row stride truncates the 16-bit element step
    apply(mk(32'h0000_1000, 2'd2, 16'd640, 16'd8, 16'd4000, 8'd1, 8'd4, 9'd90, 1'b0, 1'b0), "R3 eidx truncation");
    apply(mk(32'h0000_0040, 2'd0, 16'd1, 16'd1, 16'd0, 8'd0, 8'd0, 9'd180, 1'b0, 1'b0), "R1 single pixel byte");
    apply(mk(32'h0000_0040, 2'd0, 16'd1, 16'd1, 16'd0, 8'd0, 8'd0, 9'd270, 1'b1, 1'b0), "R4 single pixel mirror");
    // R6: legacy offset only in its one case
    apply(mk(32'h2000_0000, 2'd2, 16'd64, 16'd32, 16'd0, 8'd0, 8'd0, 9'd0, 1'b0, 1'b1), "R6 legacy bump");
    apply(mk(32'h2000_0000, 2'd2, 16'd64, 16'd32, 16'd0, 8'd0, 8'd0, 9'd0, 1'b1, 1'b1), "R6 legacy mirror none");
    apply(mk(32'h2000_0000, 2'd1, 16'd64, 16'd32, 16'd0, 8'd0, 8'd0, 9'd0, 1'b0, 1'b1), "R6 legacy 16bit none");
    apply(mk(32'h2000_0000, 2'd2, 16'd64, 16'd32, 16'd0, 8'd0, 8'd0, 9'd90, 1'b0, 1'b1), "R6 legacy rot90 none");
    // R7: rejects keep previous results
    apply(mk(32'h3000_0000, 2'd1, 16'd32, 16'd16, 16'd0, 8'd0, 8'd0, 9'd45, 1'b0, 1'b0), "R7 bad rotation");
    apply(mk(32'h3000_0000, 2'd1, 16'd32, 16'd16, 16'd0, 8'd0, 8'd0, 9'd360, 1'b0, 1'b0), "R7 rotation 360");
    apply(mk(32'h3000_0000, 2'd3, 16'd32, 16'd16, 16'd0, 8'd0, 8'd0, 9'd0, 1'b0, 1'b0), "R7 bad element size");
    apply(mk(32'h3000_0000, 2'd1, 16'd320, 16'd16, 16'd200, 8'd0, 8'd0, 9'd0, 1'b0, 1'b0), "R7 narrow vwidth");

    // R8: start while busy is ignored
    va = mk(32'h0400_0000, 2'd1, 16'd48, 16'd20, 16'd64, 8'd1, 8'd2, 9'd270, 1'b1, 1'b0);
    vb = mk(32'h0500_0000, 2'd2, 16'd10, 16'd10, 16'd0, 8'd0, 8'd0, 9'd0, 1'b0, 1'b0);
    push(va, "R8 first of overlapped");
    @(negedge clk);
    drive(va);
    start = 1'b1;
    @(negedge clk);
    drive(vb);
    n_chk++;
    if (busy !== 1'b1) begin
      $display("FAIL R8 busy after start actual=%b expected=1", busy);
      n_bad++;
    end
    @(negedge clk);
    start = 1'b0;
    wait_end();
    repeat (120) @(negedge clk);
    n_chk++;
    if (q.size() != 0 || busy !== 1'b0) begin
      $display("FAIL R8 ignored start pending actual=%0d expected=0", q.size());
      n_bad++;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule